// File: doc/BRIEF.md
# Microcontroller Clock Output Controller

This block produces the clock that a chip hands to an attached microcontroller. While the oscillator-enable control is set, the output is a 50% duty square wave: a reference clock divided by a ratio picked from a 3-bit select code. When software clears the enable, the output keeps running for a programmable count of further pulses. This tail gives the microcontroller time to reach its idle state. The output then stops low.

Once stopped, the block can optionally forward a low-frequency sleep clock of about 32 kHz in place of the divided clock. The slow clock is synchronised into the reference domain first. Every handover between sources happens only while the outgoing and incoming levels are both low, and the output comes straight from a flop. This keeps the output free of runt pulses.

A status output reports that the tail has finished and the oscillator is off. The select code and the tail length are captured together by a single write strobe.

Top module: `mco_clkout`

## Requirements
- R1: After reset `mclk_o` and `osc_off_o` are low, the active select code is 6 (ratio 10) and the stored tail length is 128.
- R2: With the enable set, `mclk_o` is high for exactly N reference cycles and low for N cycles, where select codes 0,1,2,3,4,5,6,7 give N = 1,2,3,4,5,8,10,10.
- R3: A newly written select code takes effect only at the start of a low phase, so no phase is cut short and every later pulse uses the new ratio.
- R4: Counting from the first clock edge at which `osc_en_i` is sampled low, `mclk_o` makes exactly T further rising edges, where T is the stored tail length, and then stays low.
- R5: Without any configuration write, the tail is 128 pulses long.
- R6: A stored tail length of 0 gives no further rising edge once the enable is seen low.
- R7: If the enable is set again before the tail ends, the divided clock continues without a stop and `osc_off_o` stays low.
- R8: `osc_off_o` goes high when the tail has ended, and at that point `mclk_o` is low.
- R9: While stopped with `slow_en_i` high, `mclk_o` follows the slow clock after three reference cycles of latency. It enters and leaves that mode only while the slow clock is low.
- R10: Setting the enable while stopped restarts the divider with a full low phase: the first rising edge comes N+1 cycles after the enable is driven, and `osc_off_o` falls on the first edge.
- R11: While stopped with `slow_en_i` low, `mclk_o` stays low and `osc_off_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_clk_i | input | 1 | Low-frequency sleep clock (asynchronous) |
| osc_en_i | input | 1 | Oscillator enable; clearing it starts the tail |
| slow_en_i | input | 1 | Forward the sleep clock while stopped |
| cfg_wr_i | input | 1 | Capture select code and tail length |
| div_code_i | input | 3 | Divider select code |
| tail_len_i | input | TAIL_W | Number of tail pulses |
| mclk_o | output | 1 | Clock to the microcontroller |
| osc_off_o | output | 1 | Tail finished, oscillator off |

## Verification
The bench counts tail pulses exactly for the reset default, for zero, and for a tail that is cut short by re-enabling. An off-by-one counter would show one pulse too many or too few. A design that ignored a zero length would emit a pulse, and one that ignored re-enabling would stop the clock. It measures high widths for every select code and across a ratio change, which exposes a wrong mapping or a change applied mid-phase. It also checks the restart latency from the stopped state and the forwarding of the sleep clock. A handover that did not wait for a low level would show up as a short first pulse or a wrong width.

// File: rtl/mco_pkg.sv
package mco_pkg;

   localparam int unsigned CODE_W  = 3;
   localparam int unsigned RATIO_W = 4;

   typedef enum logic [1:0] {
      ST_FAST = 2'd0,
      ST_TAIL = 2'd1,
      ST_OFF  = 2'd2,
      ST_SLOW = 2'd3
   } mco_state_e;

   // select code to half-period length in reference cycles
   function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
      logic [RATIO_W-1:0] r;
      case (code)
         3'd0:    r = 4'd1;
         3'd1:    r = 4'd2;
         3'd2:    r = 4'd3;
         3'd3:    r = 4'd4;
         3'd4:    r = 4'd5;
         3'd5:    r = 4'd8;
         default: r = 4'd10;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mco_sync.sv
module mco_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[i] <= 1'b0;
               else         chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mco_divider.sv
module mco_divider
   import mco_pkg::*;
#(
   parameter logic [CODE_W-1:0] DIV_RST = 3'd6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              restart_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              ph_o,
   output logic              tick_o
);
   logic [CODE_W-1:0]  code_q;
   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] ratio;
   logic               ph_q;

   assign ratio  = code_to_ratio(code_q);
   assign tick_o = (cnt_q == ratio - RATIO_W'(1));
   assign ph_o   = ph_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         ph_q   <= 1'b0;
         code_q <= DIV_RST;
      end else if (restart_i) begin
         cnt_q  <= '0;
         ph_q   <= 1'b0;
         code_q <= code_i;
      end else if (tick_o) begin
         cnt_q <= '0;
         ph_q  <= ~ph_q;
         // a new ratio is adopted only as a low phase begins
         if (ph_q) code_q <= code_i;
      end else begin
         cnt_q <= cnt_q + RATIO_W'(1);
      end
   end

   // R2: the phase counter never passes the active half-period
   a_r2_cnt_in_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q < ratio);

   // R3: the active code only changes when the phase is low
   a_r3_code_at_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(code_q) |-> !ph_q);
endmodule

// File: rtl/mco_seq.sv
module mco_seq
   import mco_pkg::*;
#(
   parameter int unsigned TAIL_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              osc_en_i,
   input  logic              slow_en_i,
   input  logic              slow_i,
   input  logic              tick_i,
   input  logic              ph_i,
   input  logic [TAIL_W-1:0] tail_len_i,
   output logic              restart_o,
   output logic              mclk_o,
   output logic              osc_off_o
);
   mco_state_e        st_q, st_d;
   logic [TAIL_W-1:0] rem_q, rem_d;
   logic              mclk_q, mclk_d;
   logic              rise, ph_next;

   assign rise    = tick_i & ~ph_i;
   assign ph_next = tick_i ? ~ph_i : ph_i;

   always_comb begin
      st_d   = st_q;
      rem_d  = rem_q;
      mclk_d = mclk_q;
      unique case (st_q)
         ST_FAST: begin
            mclk_d = ph_next;
            if (!osc_en_i) begin
               st_d = ST_TAIL;
               if (rise) begin
                  if (tail_len_i == '0) begin
                     st_d   = ST_OFF;
                     mclk_d = 1'b0;
                  end else begin
                     rem_d = tail_len_i - TAIL_W'(1);
                  end
               end else begin
                  rem_d = tail_len_i;
               end
            end
         end
         ST_TAIL: begin
            mclk_d = ph_next;
            if (osc_en_i) begin
               st_d = ST_FAST;
            end else if (rise) begin
               if (rem_q == '0) begin
                  st_d   = ST_OFF;
                  mclk_d = 1'b0;
               end else begin
                  rem_d = rem_q - TAIL_W'(1);
               end
            end
         end
         ST_OFF: begin
            mclk_d = 1'b0;
            if (osc_en_i)                st_d = ST_FAST;
            else if (slow_en_i && !slow_i) st_d = ST_SLOW;
         end
         default: begin
            mclk_d = slow_i;
            if ((osc_en_i || !slow_en_i) && !slow_i) begin
               st_d   = ST_OFF;
               mclk_d = 1'b0;
            end
         end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_FAST;
         rem_q  <= '0;
         mclk_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         rem_q  <= rem_d;
         mclk_q <= mclk_d;
      end
   end

   assign restart_o = (st_q == ST_OFF) || (st_q == ST_SLOW);
   assign osc_off_o = restart_o;
   assign mclk_o    = mclk_q;

   // R4: each rising edge inside the tail uses up one pulse
   a_r4_tail_count : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_TAIL && $past(st_q) == ST_TAIL && $rose(mclk_o)) |-> rem_q < $past(rem_q));

   // R6: with nothing left and the enable low, no rising edge follows
   a_r6_no_extra_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_TAIL && rem_q == '0 && !osc_en_i) |=> !$rose(mclk_o));

   // R8: the stop is reported only with the output low
   a_r8_stop_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(osc_off_o) |-> !mclk_o);

   // R9: the sleep clock is taken over while low
   a_r9_slow_entry_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_SLOW && $past(st_q) != ST_SLOW) |-> !mclk_o);

   // R11: stopped without sleep clock means a quiet output
   a_r11_off_quiet : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_OFF) |-> !mclk_o);
endmodule

// File: rtl/mco_clkout.sv
module mco_clkout
   import mco_pkg::*;
#(
   parameter int unsigned       TAIL_W      = 8,
   parameter int unsigned       TAIL_RST    = 128,
   parameter logic [CODE_W-1:0] DIV_RST     = 3'd6,
   parameter int unsigned       SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              slow_clk_i,
   input  logic              osc_en_i,
   input  logic              slow_en_i,
   input  logic              cfg_wr_i,
   input  logic [2:0]        div_code_i,
   input  logic [TAIL_W-1:0] tail_len_i,
   output logic              mclk_o,
   output logic              osc_off_o
);
   localparam logic [TAIL_W-1:0] TAIL_INIT = TAIL_W'(TAIL_RST);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mco_clkout: SYNC_STAGES must be at least 2");
      end
      if (TAIL_W < 1 || TAIL_W > 16) begin : g_bad_width
         $error("mco_clkout: TAIL_W must lie in 1..16");
      end
      if (TAIL_RST >= (1 << TAIL_W)) begin : g_bad_tail
         $error("mco_clkout: TAIL_RST does not fit in TAIL_W bits");
      end
   endgenerate

   logic [CODE_W-1:0] code_q;
   logic [TAIL_W-1:0] tail_q;
   logic              slow_s, restart, ph, tick;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q <= DIV_RST;
         tail_q <= TAIL_INIT;
      end else if (cfg_wr_i) begin
         code_q <= div_code_i;
         tail_q <= tail_len_i;
      end
   end

   mco_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (slow_clk_i),
      .q_o    (slow_s)
   );

   mco_divider #(.DIV_RST(DIV_RST)) u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .code_i    (code_q),
      .ph_o      (ph),
      .tick_o    (tick)
   );

   mco_seq #(.TAIL_W(TAIL_W)) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .osc_en_i   (osc_en_i),
      .slow_en_i  (slow_en_i),
      .slow_i     (slow_s),
      .tick_i     (tick),
      .ph_i       (ph),
      .tail_len_i (tail_q),
      .restart_o  (restart),
      .mclk_o     (mclk_o),
      .osc_off_o  (osc_off_o)
   );
endmodule

// File: tb/mco_clkout_bench.sv
module mco_clkout_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slow_clk = 1'b0;
   logic       osc_en = 1'b1;
   logic       slow_en = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] div_code = 3'd6;
   logic [7:0] tail_len = 8'd128;
   logic       mclk, osc_off;

   int tests = 0;
   int fails = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #2 clk = ~clk;

   // sleep clock: half period of 37 reference cycles
   always begin
      repeat (37) @(negedge clk);
      slow_clk = ~slow_clk;
   end

   mco_clkout u_mco_clkout (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .slow_clk_i (slow_clk),
      .osc_en_i   (osc_en),
      .slow_en_i  (slow_en),
      .cfg_wr_i   (cfg_wr),
      .div_code_i (div_code),
      .tail_len_i (tail_len),
      .mclk_o     (mclk),
      .osc_off_o  (osc_off)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: measure each high pulse and compare it with the scoreboard
   int hi_cnt = 0;
   logic prev_m = 1'b0;
   string cur_req = "R2";
   always @(negedge clk) begin
      if (rst_n) begin
         if (mclk) hi_cnt++;
         else if (prev_m) begin
            if (exp_q.size() != 0) begin
               int e;
               e = exp_q.pop_front();
               chk(hi_cnt == e, cur_req, hi_cnt, e);
            end
            hi_cnt = 0;
         end
         prev_m = mclk;
      end
   end

   task automatic expect_pulses(input int n, input int w, input string req);
      cur_req = req;
      for (int i = 0; i < n; i++) exp_q.push_back(w);
   endtask

   task automatic drain(input string req);
      int k = 0;
      while (exp_q.size() != 0 && k < 3000) begin
         @(negedge clk);
         k++;
      end
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic write_cfg(input logic [2:0] code, input logic [7:0] tl);
      div_code = code;
      tail_len = tl;
      cfg_wr   = 1'b1;
      @(negedge clk);
      cfg_wr   = 1'b0;
   endtask

   // clear the enable and count rising edges until the stop is reported
   task automatic tail_run(output int n);
      logic p;
      int k = 0;
      n = 0;
      p = mclk;
      osc_en = 1'b0;
      while (!osc_off && k < 6000) begin
         @(negedge clk);
         if (!p && mclk) n++;
         p = mclk;
         k++;
      end
   endtask

   initial begin
      int n, k, rises;
      bit seen_off;
      int ratios[8] = '{1, 2, 3, 4, 5, 8, 10, 10};
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(mclk == 1'b0, "R1 mclk", mclk, 0);
      chk(osc_off == 1'b0, "R1 osc_off", osc_off, 0);
      // R1: default ratio 10
      expect_pulses(3, 10, "R1");
      drain("R1");

      // R5: default tail of 128, R4 and R8 at its end
      tail_run(n);
      chk(n == 128, "R5", n, 128);
      chk(osc_off == 1'b1, "R8 osc_off", osc_off, 1);
      chk(mclk == 1'b0, "R8 mclk", mclk, 0);

      // R11: stopped, no sleep clock
      rises = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (mclk) rises++;
         if (!osc_off) rises++;
      end
      chk(rises == 0, "R11", rises, 0);

      // R10: restart latency with ratio 10
      osc_en = 1'b1;
      k = 0;
      @(negedge clk);
      k++;
      chk(osc_off == 1'b0, "R10 osc_off", osc_off, 0);
      while (!mclk && k < 100) begin
         @(negedge clk);
         k++;
      end
      chk(k == 11, "R10", k, 11);

      // R2: every select code
      for (int c = 0; c < 8; c++) begin
         write_cfg(3'(c), 8'd128);
         repeat (70) @(negedge clk);
         expect_pulses(3, ratios[c], "R2");
         drain("R2");
      end

      // R3: change from ratio 10 to ratio 3 while running
      write_cfg(3'd6, 8'd128);
      repeat (70) @(negedge clk);
      expect_pulses(1, 10, "R3");
      drain("R3");
      write_cfg(3'd2, 8'd128);
      repeat (45) @(negedge clk);
      expect_pulses(4, 3, "R3");
      drain("R3");

      // R7: re-enable during the tail
      write_cfg(3'd1, 8'd5);
      repeat (10) @(negedge clk);
      osc_en = 1'b0;
      rises = 0;
      begin
         logic p;
         p = mclk;
         while (rises < 2) begin
            @(negedge clk);
            if (!p && mclk) rises++;
            p = mclk;
         end
      end
      osc_en = 1'b1;
      seen_off = 1'b0;
      rises = 0;
      expect_pulses(10, 2, "R7");
      begin
         logic p;
         p = mclk;
         for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!p && mclk) rises++;
            p = mclk;
            if (osc_off) seen_off = 1'b1;
         end
      end
      chk(seen_off == 1'b0, "R7 osc_off", seen_off, 0);
      chk(rises >= 24, "R7 rises", rises, 24);
      drain("R7");

      // R4: explicit tail of 5 pulses
      tail_run(n);
      chk(n == 5, "R4", n, 5);
      osc_en = 1'b1;
      repeat (20) @(negedge clk);

      // R6: zero tail with ratio 1
      write_cfg(3'd0, 8'd0);
      repeat (5) @(negedge clk);
      tail_run(n);
      chk(n == 0, "R6", n, 0);
      chk(osc_off == 1'b1, "R6 osc_off", osc_off, 1);

      // R9: sleep clock forwarded while stopped
      slow_en = 1'b1;
      expect_pulses(3, 37, "R9");
      drain("R9");
      chk(osc_off == 1'b1, "R9 osc_off", osc_off, 1);
      slow_en = 1'b0;
      repeat (80) @(negedge clk);
      rises = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (mclk) rises++;
      end
      chk(rises == 0, "R9 leave", rises, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule